// File: doc/BRIEF.md
# Effective Address Generator

This unit turns an addressing-mode code and the operand bytes that followed an opcode into the address of the operand. It also returns the target of a PC-relative branch, and for the post-increment indexed modes it returns the advanced index value with a write strobe. Its inputs are the 16-bit index pair, the 16-bit stack pointer and the address of the next instruction. A sequencer places a request for one cycle, with all inputs stable. One clock later, the result appears on registered outputs.

Every mode is formed as a base plus an offset, and every sum wraps modulo 65536. The base is zero, the index pair, the stack pointer or the next-instruction address. The offset is none, one operand byte zero-extended, one operand byte sign-extended, or the two operand bytes as a word (high byte first). Page-zero access uses base zero with a zero-extended byte. A full 16-bit access uses base zero with the word. Fetching the operands and decoding the instruction are done elsewhere.

Top module: `eff_addr_gen`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, all outputs are cleared to zero: `ea_valid`, `hx_we`, `ea`, `br_target` and `hx_new`.
- R2: `mode` codes are 0 page-zero, 1 full, 2 index, 3 index+byte, 4 index+word, 5/6/7 the same three indexed forms with post-increment, 8 stack+byte, 9 stack+word, 10 relative. A request with a legal code raises `ea_valid` for exactly the next cycle. A cycle without a request leaves `ea_valid` and `hx_we` low, and `ea`, `br_target` and `hx_new` unchanged.
- R3: In page-zero mode, `ea` = {8'h00, `opnd_lo`}, so the high byte is always zero.
- R4: In full mode, `ea` = {`opnd_hi`, `opnd_lo`}.
- R5: In the indexed modes, `ea` = `hx` + 0, `hx` + zero-extended `opnd_lo`, or `hx` + {`opnd_hi`,`opnd_lo`}, modulo 65536.
- R6: The post-increment modes give the same `ea` as their plain forms, computed from the pre-increment `hx`. In the same cycle they give `hx_new` = `hx` + 1 modulo 65536 with `hx_we` high. All other modes leave `hx_we` low.
- R7: In the stack modes, `ea` = `sp` + zero-extended `opnd_lo`, or `sp` + {`opnd_hi`,`opnd_lo`}, modulo 65536.
- R8: In relative mode, `ea` = `pc_next` + sign-extended `opnd_lo` (range -128..+127), modulo 65536.
- R9: Every accepted request, whatever its mode, updates `br_target` to `pc_next` + sign-extended `opnd_lo`.
- R10: A request with a reserved code (11 to 15) is ignored. `ea_valid` and `hx_we` stay low, and `ea`, `br_target` and `hx_new` keep their values.
- R11: Requests on consecutive cycles each produce their own result, one cycle after each request, with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle per address |
| mode | input | 4 | Addressing-mode code (see R2) |
| opnd_hi | input | 8 | First operand byte after the opcode (high byte of a word) |
| opnd_lo | input | 8 | Last operand byte (low byte, or the single byte) |
| hx | input | 16 | Current index pair |
| sp | input | 16 | Current stack pointer |
| pc_next | input | 16 | Address of the instruction after the current one |
| ea_valid | output | 1 | Result valid, one cycle per legal request |
| ea | output | 16 | Effective operand address |
| br_target | output | 16 | Relative branch destination |
| hx_new | output | 16 | Index pair after post-increment |
| hx_we | output | 1 | Write strobe for `hx_new` |

## Verification
The bench builds the block with its default widths: a 16-bit address and 8-bit operand bytes. With these widths the carry out of bit 15 can be reached with small operands. The vector table places bases and offsets where each sum crosses 0xFFFF or a 256-byte page: index 0xFFFF with post-increment, stack pointer plus a word, and relative offsets of 0x80 and 0x7F. This exposes a missing wrap, a sign-extension error or a zero-extension error at a known value. Directed cases then cover reserved codes, idle cycles, back-to-back requests and reset during operation.

// File: rtl/eag_pkg.sv
// Package: shared types for the effective address generator.
// Holds the mode codes, the base and offset selector types, and small
// helper functions. Assumes a 4-bit mode field.
package eag_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        M_PAGE0   = 4'd0,
        M_FULL    = 4'd1,
        M_IX      = 4'd2,
        M_IX_B    = 4'd3,
        M_IX_W    = 4'd4,
        M_IX_INC  = 4'd5,
        M_IXB_INC = 4'd6,
        M_IXW_INC = 4'd7,
        M_SP_B    = 4'd8,
        M_SP_W    = 4'd9,
        M_REL     = 4'd10
    } mode_e;

    typedef enum logic [1:0] {
        BASE_ZERO = 2'd0,
        BASE_HX   = 2'd1,
        BASE_SP   = 2'd2,
        BASE_PC   = 2'd3
    } base_e;

    typedef enum logic [1:0] {
        OFF_NONE = 2'd0,
        OFF_ZB   = 2'd1,
        OFF_SB   = 2'd2,
        OFF_WORD = 2'd3
    } off_e;

    typedef struct packed {
        base_e base;
        off_e  off;
        logic  inc;
        logic  legal;
    } ctl_t;

    // True for the three indexed forms that advance the index pair.
    function automatic logic mode_is_inc(logic [MODE_W-1:0] m);
        return (m == M_IX_INC) || (m == M_IXB_INC) || (m == M_IXW_INC);
    endfunction

endpackage

// File: rtl/eag_mode_dec.sv
// Module: mode decoder.
// Maps a mode code onto a base selector, an offset selector, a
// post-increment flag and a legality flag. Purely combinational.
// Assumes codes above M_REL are reserved.
module eag_mode_dec
    import eag_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output ctl_t              ctl
);

    // Decode the mode into base/offset selection.
    always_comb begin
        ctl       = '{base: BASE_ZERO, off: OFF_NONE, inc: 1'b0, legal: 1'b1};
        ctl.inc   = mode_is_inc(mode);
        case (mode)
            M_PAGE0:   begin ctl.base = BASE_ZERO; ctl.off = OFF_ZB;   end
            M_FULL:    begin ctl.base = BASE_ZERO; ctl.off = OFF_WORD; end
            M_IX,
            M_IX_INC:  begin ctl.base = BASE_HX;   ctl.off = OFF_NONE; end
            M_IX_B,
            M_IXB_INC: begin ctl.base = BASE_HX;   ctl.off = OFF_ZB;   end
            M_IX_W,
            M_IXW_INC: begin ctl.base = BASE_HX;   ctl.off = OFF_WORD; end
            M_SP_B:    begin ctl.base = BASE_SP;   ctl.off = OFF_ZB;   end
            M_SP_W:    begin ctl.base = BASE_SP;   ctl.off = OFF_WORD; end
            M_REL:     begin ctl.base = BASE_PC;   ctl.off = OFF_SB;   end
            default:   begin ctl.legal = 1'b0;     ctl.inc = 1'b0;     end
        endcase
    end

endmodule

// File: rtl/eag_offset.sv
// Module: operand extension.
// Builds the zero-extended byte, the sign-extended byte and the word
// from the operand bytes. Assumes ADDR_W is a multiple of BYTE_W and
// at least twice BYTE_W; bytes above the two operands are zero.
module eag_offset #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] opnd_hi,
    input  logic [BYTE_W-1:0] opnd_lo,
    output logic [ADDR_W-1:0] off_zb,
    output logic [ADDR_W-1:0] off_sb,
    output logic [ADDR_W-1:0] off_word
);

    localparam int PAD_B = ADDR_W - BYTE_W;
    localparam int PAD_W = ADDR_W - 2 * BYTE_W;

    // Zero and sign extension of the single byte.
    always_comb begin
        off_zb = {{PAD_B{1'b0}}, opnd_lo};
        off_sb = {{PAD_B{opnd_lo[BYTE_W-1]}}, opnd_lo};
    end

    // Word form: padded only when the address is wider than two bytes.
    generate
        if (PAD_W > 0) begin : g_pad
            assign off_word = {{PAD_W{1'b0}}, opnd_hi, opnd_lo};
        end else begin : g_exact
            assign off_word = {opnd_hi, opnd_lo};
        end
    endgenerate

endmodule

// File: rtl/eag_sum.sv
// Module: base/offset adder.
// Selects a base and an offset and adds them modulo 2**ADDR_W. Also
// forms the branch destination and the incremented index on adders of
// their own, so that no path goes through the mode mux twice.
module eag_sum
    import eag_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  ctl_t              ctl,
    input  logic [ADDR_W-1:0] hx,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] pc_next,
    input  logic [ADDR_W-1:0] off_zb,
    input  logic [ADDR_W-1:0] off_sb,
    input  logic [ADDR_W-1:0] off_word,
    output logic [ADDR_W-1:0] ea_c,
    output logic [ADDR_W-1:0] br_c,
    output logic [ADDR_W-1:0] hx_inc_c
);

    logic [ADDR_W-1:0] base_v;
    logic [ADDR_W-1:0] off_v;

    // Base selection.
    always_comb begin
        case (ctl.base)
            BASE_HX:  base_v = hx;
            BASE_SP:  base_v = sp;
            BASE_PC:  base_v = pc_next;
            default:  base_v = '0;
        endcase
    end

    // Offset selection.
    always_comb begin
        case (ctl.off)
            OFF_ZB:   off_v = off_zb;
            OFF_SB:   off_v = off_sb;
            OFF_WORD: off_v = off_word;
            default:  off_v = '0;
        endcase
    end

    // Address sums; carries beyond ADDR_W are discarded.
    always_comb begin
        ea_c     = base_v + off_v;
        br_c     = pc_next + off_sb;
        hx_inc_c = hx + {{(ADDR_W-1){1'b0}}, 1'b1};
    end

endmodule

// File: rtl/eag_out_reg.sv
// Module: output register stage.
// Captures the results of an accepted request. Data registers hold
// their values between requests; the strobes last one cycle.
// Synchronous active-low reset clears everything.
module eag_out_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              inc,
    input  logic [ADDR_W-1:0] ea_c,
    input  logic [ADDR_W-1:0] br_c,
    input  logic [ADDR_W-1:0] hx_inc_c,
    output logic              ea_valid,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] br_target,
    output logic [ADDR_W-1:0] hx_new,
    output logic              hx_we
);

    // Strobes: high for exactly the cycle after an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_valid <= 1'b0;
            hx_we    <= 1'b0;
        end else begin
            ea_valid <= accept;
            hx_we    <= accept & inc;
        end
    end

    // Address registers: load on an accepted request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea        <= '0;
            br_target <= '0;
        end else if (accept) begin
            ea        <= ea_c;
            br_target <= br_c;
        end
    end

    // Index register copy: load only when post-increment is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hx_new <= '0;
        end else if (accept && inc) begin
            hx_new <= hx_inc_c;
        end
    end

endmodule

// File: rtl/eff_addr_gen.sv
// Module: effective address generator (top).
// Decodes the mode, extends the operands, adds them to the selected
// base, and registers the results one cycle after req_valid.
// Assumes all inputs are stable in the request cycle.
module eff_addr_gen
    import eag_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        mode,
    input  logic [BYTE_W-1:0] opnd_hi,
    input  logic [BYTE_W-1:0] opnd_lo,
    input  logic [ADDR_W-1:0] hx,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] pc_next,
    output logic              ea_valid,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] br_target,
    output logic [ADDR_W-1:0] hx_new,
    output logic              hx_we
);

    ctl_t              ctl;
    logic [ADDR_W-1:0] off_zb, off_sb, off_word;
    logic [ADDR_W-1:0] ea_c, br_c, hx_inc_c;
    logic              accept;

    eag_mode_dec u_dec (
        .mode (mode),
        .ctl  (ctl)
    );

    eag_offset #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_off (
        .opnd_hi  (opnd_hi),
        .opnd_lo  (opnd_lo),
        .off_zb   (off_zb),
        .off_sb   (off_sb),
        .off_word (off_word)
    );

    eag_sum #(.ADDR_W(ADDR_W)) u_sum (
        .ctl      (ctl),
        .hx       (hx),
        .sp       (sp),
        .pc_next  (pc_next),
        .off_zb   (off_zb),
        .off_sb   (off_sb),
        .off_word (off_word),
        .ea_c     (ea_c),
        .br_c     (br_c),
        .hx_inc_c (hx_inc_c)
    );

    // A request is taken only when its mode code is legal.
    always_comb accept = req_valid & ctl.legal;

    eag_out_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .inc       (ctl.inc),
        .ea_c      (ea_c),
        .br_c      (br_c),
        .hx_inc_c  (hx_inc_c),
        .ea_valid  (ea_valid),
        .ea        (ea),
        .br_target (br_target),
        .hx_new    (hx_new),
        .hx_we     (hx_we)
    );

endmodule

// File: rtl/eag_checker.sv
// Module: protocol and arithmetic checker for eff_addr_gen.
// Observes only the top-level ports and is attached with bind.
module eag_checker #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [3:0]        mode,
    input logic [BYTE_W-1:0] opnd_hi,
    input logic [BYTE_W-1:0] opnd_lo,
    input logic [ADDR_W-1:0] hx,
    input logic [ADDR_W-1:0] sp,
    input logic [ADDR_W-1:0] pc_next,
    input logic              ea_valid,
    input logic [ADDR_W-1:0] ea,
    input logic [ADDR_W-1:0] br_target,
    input logic [ADDR_W-1:0] hx_new,
    input logic              hx_we
);

    localparam int PAD_B = ADDR_W - BYTE_W;

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!ea_valid && !hx_we && $stable(ea) && $stable(br_target)));

    p_page0_high_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 4'd0) |=> (ea_valid && ea[ADDR_W-1:BYTE_W] == '0));

    p_full_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 4'd1) |=> (ea[BYTE_W-1:0] == $past(opnd_lo)));

    p_postinc_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode >= 4'd5 && mode <= 4'd7)
            |=> (hx_we && hx_new == $past(hx) + 1'b1));

    p_strobe_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hx_we |-> ea_valid);

    p_rel_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 4'd10)
            |=> (ea == br_target &&
                 br_target == $past(pc_next) + {{PAD_B{$past(opnd_lo[BYTE_W-1])}}, $past(opnd_lo)}));

    p_reserved_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode >= 4'd11)
            |=> (!ea_valid && !hx_we && $stable(ea) && $stable(hx_new)));

    p_back_to_back_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode <= 4'd10) |=> ea_valid);

endmodule

bind eff_addr_gen eag_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .mode      (mode),
    .opnd_hi   (opnd_hi),
    .opnd_lo   (opnd_lo),
    .hx        (hx),
    .sp        (sp),
    .pc_next   (pc_next),
    .ea_valid  (ea_valid),
    .ea        (ea),
    .br_target (br_target),
    .hx_new    (hx_new),
    .hx_we     (hx_we)
);

// File: tb/sim_eff_addr_gen.sv
`timescale 1ns/1ps
// Bench: vector table walk, then directed reset and corner cases.
module sim_eff_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic [7:0]  opnd_hi = '0, opnd_lo = '0;
    logic [15:0] hx = '0, sp = '0, pc_next = '0;
    logic        ea_valid, hx_we;
    logic [15:0] ea, br_target, hx_new;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    eff_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
        .opnd_hi(opnd_hi), .opnd_lo(opnd_lo), .hx(hx), .sp(sp),
        .pc_next(pc_next), .ea_valid(ea_valid), .ea(ea),
        .br_target(br_target), .hx_new(hx_new), .hx_we(hx_we)
    );

    typedef struct packed {
        logic [3:0]  m;
        logic [7:0]  hi;
        logic [7:0]  lo;
        logic [15:0] x;
        logic [15:0] s;
        logic [15:0] p;
        logic [15:0] exp_ea;
        logic        exp_we;
        logic [15:0] exp_hxn;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  8'h12, 8'hAB, 16'h5555, 16'h0000, 16'h0000, 16'h00AB, 1'b0, 16'h0000}, // R3
        '{4'd1,  8'hE0, 8'h00, 16'h5555, 16'h0000, 16'h0000, 16'hE000, 1'b0, 16'h0000}, // R4
        '{4'd2,  8'h00, 8'h00, 16'h1234, 16'h0000, 16'h0000, 16'h1234, 1'b0, 16'h0000}, // R5
        '{4'd3,  8'h00, 8'hFF, 16'h1234, 16'h0000, 16'h0000, 16'h1333, 1'b0, 16'h0000}, // R5
        '{4'd4,  8'h10, 8'h01, 16'hF000, 16'h0000, 16'h0000, 16'h0001, 1'b0, 16'h0000}, // R5
        '{4'd5,  8'h00, 8'h00, 16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF, 1'b1, 16'h0000}, // R6
        '{4'd6,  8'h00, 8'h80, 16'h00FF, 16'h0000, 16'h0000, 16'h017F, 1'b1, 16'h0100}, // R6
        '{4'd7,  8'h00, 8'h10, 16'h2000, 16'h0000, 16'h0000, 16'h2010, 1'b1, 16'h2001}, // R6
        '{4'd8,  8'h00, 8'h01, 16'h0000, 16'h00FF, 16'h0000, 16'h0100, 1'b0, 16'h0000}, // R7
        '{4'd9,  8'hFF, 8'h02, 16'h0000, 16'h00FF, 16'h0000, 16'h0001, 1'b0, 16'h0000}, // R7
        '{4'd10, 8'h00, 8'h80, 16'h0000, 16'h0000, 16'h1000, 16'h0F80, 1'b0, 16'h0000}, // R8
        '{4'd10, 8'h00, 8'h7F, 16'h0000, 16'h0000, 16'h1000, 16'h107F, 1'b0, 16'h0000}, // R8
        '{4'd10, 8'h00, 8'hF0, 16'h0000, 16'h0000, 16'h0010, 16'h0000, 1'b0, 16'h0000}, // R8
        '{4'd10, 8'h00, 8'h20, 16'h0000, 16'h0000, 16'hFFF0, 16'h0010, 1'b0, 16'h0000}  // R8
    };

    // Branch destination per R9: next address plus sign-extended byte.
    function automatic logic [15:0] rel_dest(logic [15:0] p, logic [7:0] b);
        return p + {{8{b[7]}}, b};
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(logic [3:0] m, logic [7:0] h, logic [7:0] l,
                         logic [15:0] x, logic [15:0] s, logic [15:0] p);
        mode = m; opnd_hi = h; opnd_lo = l; hx = x; sp = s; pc_next = p;
        req_valid = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] held_ea, held_br, held_hxn;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ea_valid", {15'd0, ea_valid}, 16'd0);
        chk("R1 hx_we", {15'd0, hx_we}, 16'd0);
        chk("R1 ea", ea, 16'h0000);
        chk("R1 br_target", br_target, 16'h0000);
        chk("R1 hx_new", hx_new, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            logic [15:0] prev_hxn;
            prev_hxn = hx_new;
            drive(VECS[i].m, VECS[i].hi, VECS[i].lo, VECS[i].x, VECS[i].s, VECS[i].p);
            @(negedge clk);
            req_valid = 1'b0;
            chk("R2 ea_valid", {15'd0, ea_valid}, 16'd1);
            chk("R3-8 ea", ea, VECS[i].exp_ea);
            chk("R6 hx_we", {15'd0, hx_we}, {15'd0, VECS[i].exp_we});
            chk("R6 hx_new", hx_new, VECS[i].exp_we ? VECS[i].exp_hxn : prev_hxn);
            chk("R9 br_target", br_target, rel_dest(VECS[i].p, VECS[i].lo));
        end

        // R2: idle cycle keeps data, drops strobes
        held_ea = ea; held_br = br_target; held_hxn = hx_new;
        mode = 4'd1; opnd_hi = 8'h77; opnd_lo = 8'h66;
        @(negedge clk);
        chk("R2 idle ea_valid", {15'd0, ea_valid}, 16'd0);
        chk("R2 idle ea", ea, held_ea);
        chk("R2 idle br_target", br_target, held_br);

        // R10: reserved codes are ignored
        for (int c = 11; c < 16; c++) begin
            drive(4'(c), 8'h33, 8'h44, 16'hAAAA, 16'hBBBB, 16'hCCCC);
            @(negedge clk);
            req_valid = 1'b0;
            chk("R10 ea_valid", {15'd0, ea_valid}, 16'd0);
            chk("R10 hx_we", {15'd0, hx_we}, 16'd0);
            chk("R10 ea", ea, held_ea);
            chk("R10 br_target", br_target, held_br);
            chk("R10 hx_new", hx_new, held_hxn);
        end

        // R11: back-to-back requests, then a non-increment after an increment
        drive(4'd5, 8'h00, 8'h00, 16'h4000, 16'h0000, 16'h0100);
        @(negedge clk);
        chk("R11 first ea", ea, 16'h4000);
        chk("R11 first hx_new", hx_new, 16'h4001);
        drive(4'd8, 8'h00, 8'h05, 16'h4001, 16'h0200, 16'h0100);
        @(negedge clk);
        chk("R11 second ea", ea, 16'h0205);
        chk("R11 second ea_valid", {15'd0, ea_valid}, 16'd1);
        chk("R6 second hx_we low", {15'd0, hx_we}, 16'd0);
        drive(4'd0, 8'hFF, 8'hFF, 16'h0000, 16'h0000, 16'h0100);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 third ea", ea, 16'h00FF);
        chk("R3 page0 high byte", ea & 16'hFF00, 16'h0000);

        // R1: reset mid-run clears results
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid ea", ea, 16'h0000);
        chk("R1 mid hx_new", hx_new, 16'h0000);
        chk("R1 mid br_target", br_target, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule